// File: doc/BRIEF.md
# Variable-Length Serial Master Shift Engine

This block is a serial-peripheral master that moves one character per transfer through a 16-bit shift register. Software picks a character length from 1 to 16 bits with a 4-bit field. It writes the outgoing word left-justified into the transmit port. A write while the engine is idle starts the transfer. The engine produces a serial clock from the system clock through a programmable divider. The serial clock idles low. The engine drives the register's top bit on the data-out line and moves the input line into the bottom bit, one bit per serial clock.

When the last bit of a character has moved, the whole shift register is copied into a receive buffer and a completion flag is raised. For short characters, the new bits therefore sit right-justified in the buffer, and the remains of earlier traffic sit shifted up above them. If a character lands while the previous one is still unread, a sticky overrun flag is set. Software clears it with its own strobe. The completion and overrun flags, each gated by its own enable, share one interrupt output.

Top module: `spi_var_shifter`

## Requirements
- R1: After reset, busy, sclk, cmp_flag, ovr_flag and irq are 0 and rx_data is 16'h0000.
- R2: A one-cycle tx_wr pulse while idle starts a transfer of char_len+1 bits. busy is 1 for exactly 2*(char_len+1)*(clk_div+1) cycles, beginning at the edge that accepts the write, and sclk shows exactly char_len+1 rising edges.
- R3: mosi presents the shift register's bit 15 first. The bits seen at the sclk rising edges are the top char_len+1 bits of tx_data, MSB first.
- R4: miso is sampled on each sclk rising edge and enters bit 0 at the following falling edge. At completion, rx_data equals ((tx_data << n) | s) truncated to 16 bits, where n is the bit count and s holds the n received bits, first-received bit most significant. Example: with 16'h737B, one bit and miso high, rx_data is 16'hE6F7.
- R5: sclk is low whenever busy is 0. Each sclk half-period lasts clk_div+1 system cycles, and data changes only on the falling edge.
- R6: tx_wr while busy is 1 has no effect: the running transfer keeps its data, length and duration.
- R7: cmp_flag is set at the edge where busy falls and is cleared by an rx_rd pulse. An rx_rd in the same cycle as completion leaves cmp_flag set.
- R8: ovr_flag is set when a character completes while cmp_flag is still 1 and no rx_rd is present in that cycle. ovr_flag stays set across rx_rd and further transfers until an ovr_clr pulse.
- R9: irq is 1 exactly when (cmp_flag and cmp_ie) or (ovr_flag and ovr_ie) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr | input | 1 | Transmit write strobe; starts a transfer when idle |
| tx_data | input | 16 | Left-justified transmit word |
| char_len | input | 4 | Character length minus one |
| clk_div | input | 8 | Serial clock half-period minus one, in system cycles |
| rx_rd | input | 1 | Receive buffer read strobe |
| ovr_clr | input | 1 | Overrun flag clear strobe |
| cmp_ie | input | 1 | Completion interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rx_data | output | 16 | Receive buffer |
| busy | output | 1 | Transfer in progress |
| cmp_flag | output | 1 | Character complete, unread |
| ovr_flag | output | 1 | Receive overrun, sticky |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A buffer read and the landing of a new character can fall in the same cycle, and the outcome decides whether an overrun is recorded. The bench leaves one character unread. It then times an rx_rd pulse to the exact completion edge, which it computes from the length and divider values. It expects cmp_flag to stay set and ovr_flag to stay clear. It repeats the sequence with the read one cycle late and expects the overrun to be flagged.

// File: rtl/spi_vs_pkg.sv
package spi_vs_pkg;

   // Serial clock edge produced by the divider in the current cycle.
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_RISE = 2'd1,
      EV_FALL = 2'd2
   } sclk_ev_e;

   function automatic int unsigned len_bits(input int unsigned w);
      return (w <= 1) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/spi_vs_clkgen.sv
module spi_vs_clkgen
   import spi_vs_pkg::*;
#(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output sclk_ev_e         ev
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic             sclk_q;
   logic             tick;

   assign tick = run && (cnt_q == div_q);

   always_comb begin
      ev = EV_NONE;
      if (tick) begin
         ev = sclk_q ? EV_FALL : EV_RISE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         div_q  <= '0;
         sclk_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         div_q  <= div;
         sclk_q <= 1'b0;
      end else if (run) begin
         if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end
   end

   assign sclk = sclk_q;

endmodule

// File: rtl/spi_vs_shifter.sv
module spi_vs_shifter
   import spi_vs_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [W-1:0]     ld_data,
   input  logic [LEN_W-1:0] ld_len,
   input  sclk_ev_e         ev,
   input  logic             miso,
   output logic             busy,
   output logic             mosi,
   output logic             done,
   output logic [W-1:0]     rx_word
);

   logic [W-1:0]     sh_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             smp_q;
   logic             busy_q;
   logic             last_bit;

   assign last_bit = (cnt_q == len_q);
   assign done     = busy_q && (ev == EV_FALL) && last_bit;
   assign rx_word  = {sh_q[W-2:0], smp_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         len_q  <= '0;
         smp_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (start) begin
         sh_q   <= ld_data;
         cnt_q  <= '0;
         len_q  <= ld_len;
         smp_q  <= 1'b0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (ev == EV_RISE) begin
            smp_q <= miso;
         end
         if (ev == EV_FALL) begin
            sh_q <= {sh_q[W-2:0], smp_q};
            if (last_bit) begin
               busy_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign mosi = sh_q[W-1];

endmodule

// File: rtl/spi_vs_status.sv
module spi_vs_status #(
   parameter int unsigned W       = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         done,
   input  logic [W-1:0] rx_word,
   input  logic         rx_rd,
   input  logic         ovr_clr,
   input  logic         cmp_ie,
   input  logic         ovr_ie,
   output logic [W-1:0] rx_data,
   output logic         cmp_flag,
   output logic         ovr_flag,
   output logic         irq
);

   logic [W-1:0] buf_q;
   logic         cmp_q;
   logic         ovr_q;
   logic         irq_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cmp_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (done) begin
            buf_q <= rx_word;
         end
         if (done) begin
            cmp_q <= 1'b1;
         end else if (rx_rd) begin
            cmp_q <= 1'b0;
         end
         if (done && cmp_q && !rx_rd) begin
            ovr_q <= 1'b1;
         end else if (ovr_clr) begin
            ovr_q <= 1'b0;
         end
      end
   end

   assign irq_d = (cmp_q && cmp_ie) || (ovr_q && ovr_ie);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_d;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_d;
      end
   endgenerate

   assign rx_data  = buf_q;
   assign cmp_flag = cmp_q;
   assign ovr_flag = ovr_q;

endmodule

// File: rtl/spi_var_shifter.sv
module spi_var_shifter
   import spi_vs_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LEN_W   = len_bits(DATA_W),
   parameter int unsigned DIV_W   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [LEN_W-1:0]  char_len,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              rx_rd,
   input  logic              ovr_clr,
   input  logic              cmp_ie,
   input  logic              ovr_ie,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              cmp_flag,
   output logic              ovr_flag,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);

   localparam int unsigned MAX_LEN = 1 << LEN_W;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_var_shifter: DATA_W must be at least 2");
      end
      if (MAX_LEN != DATA_W) begin : g_bad_len
         $error("spi_var_shifter: length field must span exactly 1..DATA_W");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_var_shifter: DIV_W must be at least 1");
      end
   endgenerate

   sclk_ev_e          ev;
   logic              start;
   logic              done;
   logic              busy_i;
   logic [DATA_W-1:0] rx_word;

   assign start = tx_wr && !busy_i;

   spi_vs_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (busy_i),
      .div   (clk_div),
      .sclk  (sclk),
      .ev    (ev)
   );

   spi_vs_shifter #(.W(DATA_W), .LEN_W(LEN_W)) u_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ld_data (tx_data),
      .ld_len  (char_len),
      .ev      (ev),
      .miso    (miso),
      .busy    (busy_i),
      .mosi    (mosi),
      .done    (done),
      .rx_word (rx_word)
   );

   spi_vs_status #(.W(DATA_W), .IRQ_REG(IRQ_REG)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .rx_word  (rx_word),
      .rx_rd    (rx_rd),
      .ovr_clr  (ovr_clr),
      .cmp_ie   (cmp_ie),
      .ovr_ie   (ovr_ie),
      .rx_data  (rx_data),
      .cmp_flag (cmp_flag),
      .ovr_flag (ovr_flag),
      .irq      (irq)
   );

   assign busy = busy_i;

endmodule

// File: rtl/spi_vs_chk.sv
module spi_vs_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_wr,
   input logic              ovr_clr,
   input logic              busy,
   input logic              sclk,
   input logic              mosi,
   input logic [DATA_W-1:0] rx_data,
   input logic              cmp_flag,
   input logic              ovr_flag,
   input logic              irq
);

   p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sclk) |-> $stable(mosi));

   p_start_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_wr));

   p_cmp_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> cmp_flag);

   p_rxbuf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(rx_data));

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clr) |=> ovr_flag);

   p_ovr_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> ($fell(busy) && cmp_flag));

   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cmp_flag || ovr_flag || $past(cmp_flag) || $past(ovr_flag)));

endmodule

bind spi_var_shifter spi_vs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_wr    (tx_wr),
   .ovr_clr  (ovr_clr),
   .busy     (busy),
   .sclk     (sclk),
   .mosi     (mosi),
   .rx_data  (rx_data),
   .cmp_flag (cmp_flag),
   .ovr_flag (ovr_flag),
   .irq      (irq)
);

// File: tb/spi_var_shifter_bench.sv
`timescale 1ns/1ps
module spi_var_shifter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_wr = 1'b0;
   logic [15:0] tx_data = '0;
   logic [3:0]  char_len = '0;
   logic [7:0]  clk_div = '0;
   logic        rx_rd = 1'b0;
   logic        ovr_clr = 1'b0;
   logic        cmp_ie = 1'b0;
   logic        ovr_ie = 1'b0;
   logic [15:0] rx_data;
   logic        busy, cmp_flag, ovr_flag, irq, sclk, mosi;
   logic        miso;

   int total = 0;
   int bad = 0;

   logic [15:0] sl_sh = '0;
   int          n_cur = 1;
   logic [15:0] mo_cap = '0;
   int          rise_cnt = 0;

   always #2 clk = ~clk;

   spi_var_shifter u_spi_var_shifter (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
      .char_len(char_len), .clk_div(clk_div), .rx_rd(rx_rd),
      .ovr_clr(ovr_clr), .cmp_ie(cmp_ie), .ovr_ie(ovr_ie),
      .rx_data(rx_data), .busy(busy), .cmp_flag(cmp_flag),
      .ovr_flag(ovr_flag), .irq(irq), .sclk(sclk), .mosi(mosi),
      .miso(miso)
   );

   // Slave model: presents its bits MSB-first, advancing on sclk falling edges.
   assign miso = sl_sh[n_cur-1];
   always @(negedge sclk) sl_sh = sl_sh << 1;
   always @(posedge sclk) begin
      mo_cap   = {mo_cap[14:0], mosi};
      rise_cnt = rise_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] tx, input logic [3:0] lf, input logic [7:0] dv,
                       input logic [15:0] sl, input int rd_at,
                       input bit wr2, input logic [15:0] tx2);
      int n, nc, bcnt;
      logic [31:0] exp_rx, mask;
      n  = int'(lf) + 1;
      nc = 2 * n * (int'(dv) + 1);
      @(negedge clk);
      char_len = lf; clk_div = dv; sl_sh = sl; n_cur = n;
      mo_cap = '0; rise_cnt = 0; tx_data = tx; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; bcnt = 0;
      for (int k = 0; k < nc + 3; k++) begin
         if (busy) bcnt++;
         rx_rd   = (rd_at == k + 1);
         tx_wr   = wr2 && (k == 3);
         tx_data = (wr2 && (k == 3)) ? tx2 : tx;
         @(negedge clk);
      end
      rx_rd = 1'b0; tx_wr = 1'b0;
      mask   = (32'd1 << n) - 1;
      exp_rx = ((32'(tx) << n) | (32'(sl) & mask)) & 32'hFFFF;
      chk("R2 busy cycles", bcnt, nc);
      chk("R2 sclk rises", rise_cnt, n);
      chk("R3 mosi bits", 32'(mo_cap) & mask, 32'(tx) >> (16 - n));
      chk("R4 rx buffer", 32'(rx_data), exp_rx);
      chk("R5 sclk idle", 32'(sclk), 0);
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy), 0);
      chk("R1 sclk", 32'(sclk), 0);
      chk("R1 cmp", 32'(cmp_flag), 0);
      chk("R1 ovr", 32'(ovr_flag), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rx", 32'(rx_data), 0);
   endtask

   task automatic pulse_rd();
      @(negedge clk) rx_rd = 1'b1;
      @(negedge clk) rx_rd = 1'b0;
   endtask

   task automatic t_full16();
      cmp_ie = 1'b1; ovr_ie = 1'b0;
      xfer(16'hA5C3, 4'd15, 8'd1, 16'h3C96, -1, 1'b0, 16'h0);
      chk("R7 cmp set", 32'(cmp_flag), 1);
      chk("R9 irq on cmp", 32'(irq), 1);
      pulse_rd();
      chk("R7 cmp cleared by read", 32'(cmp_flag), 0);
      chk("R9 irq drops", 32'(irq), 0);
   endtask

   task automatic t_one_bit();
      xfer(16'h737B, 4'd0, 8'd2, 16'h0001, -1, 1'b0, 16'h0);
      chk("R4 one-bit example", 32'(rx_data), 32'hE6F7);
      pulse_rd();
   endtask

   task automatic t_five_bit();
      xfer(16'hBC3F, 4'd4, 8'd0, 16'h000D, -1, 1'b0, 16'h0);
      chk("R4 five-bit leftovers", 32'(rx_data), 32'h87ED);
      pulse_rd();
      xfer(16'h8000, 4'd8, 8'd3, 16'h0155, -1, 1'b0, 16'h0);
      pulse_rd();
   endtask

   task automatic t_busy_ignore();
      xfer(16'h1234, 4'd11, 8'd1, 16'h0ABC, -1, 1'b1, 16'hFFFF);
      chk("R6 write while busy ignored", 32'(rx_data), 32'h4ABC);
      pulse_rd();
   endtask

   task automatic t_overrun();
      cmp_ie = 1'b0; ovr_ie = 1'b1;
      xfer(16'hF000, 4'd3, 8'd0, 16'h0005, -1, 1'b0, 16'h0);
      chk("R8 no ovr on first", 32'(ovr_flag), 0);
      chk("R9 irq masked cmp", 32'(irq), 0);
      xfer(16'h0F00, 4'd3, 8'd0, 16'h000A, -1, 1'b0, 16'h0);
      chk("R8 ovr set", 32'(ovr_flag), 1);
      chk("R9 irq on ovr", 32'(irq), 1);
      pulse_rd();
      chk("R8 ovr survives read", 32'(ovr_flag), 1);
      @(negedge clk) ovr_clr = 1'b1;
      @(negedge clk) ovr_clr = 1'b0;
      chk("R8 ovr cleared", 32'(ovr_flag), 0);
      chk("R9 irq idle", 32'(irq), 0);
   endtask

   task automatic t_collide();
      int nc;
      xfer(16'hC000, 4'd1, 8'd1, 16'h0002, -1, 1'b0, 16'h0);
      nc = 2 * 2 * 2;
      xfer(16'h4000, 4'd1, 8'd1, 16'h0001, nc, 1'b0, 16'h0);
      chk("R7 read at completion keeps cmp", 32'(cmp_flag), 1);
      chk("R8 read at completion avoids ovr", 32'(ovr_flag), 0);
      xfer(16'h8000, 4'd1, 8'd1, 16'h0003, nc + 1, 1'b0, 16'h0);
      chk("R8 late read gives ovr", 32'(ovr_flag), 1);
      chk("R7 late read clears cmp", 32'(cmp_flag), 0);
      @(negedge clk) ovr_clr = 1'b1;
      @(negedge clk) ovr_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full16();
      t_one_bit();
      t_five_bit();
      t_busy_ignore();
      t_overrun();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule